// File: doc/BRIEF.md
# CTS Change Interrupt Latch

This block keeps the interrupt status flag for the Clear-To-Send modem input of a serial port, inside the serial port's own clock domain. The pin is asynchronous, so it is brought in through a short flop chain. Every change of its synchronized level, high-going or low-going, raises the status flag. The flag then holds until software clears it.

Clearing works through a one-bit, write-only clear control. Only a 0-to-1 change of that hidden bit clears the flag. The hardware drops the bit back to 0 on every cycle in which the flag is 0, so one write of 1 normally clears the flag and arms the control again. If a new pin change arrives in the same cycle as the clear, the pin change wins. The flag stays set and the hidden bit stays at 1, so further writes of 1 have no effect. Software recovers by writing 0 and then 1. The block models this lost-clear case exactly. A mask input gates the flag onto the interrupt line.

Top module: `cts_irq_latch`

## Requirements
- R1: `cts_sync_o` follows `cts_async_i` through two flops. A pin level applied before a rising clock edge appears on `cts_sync_o` after the second rising edge.
- R2: A change of `cts_sync_o`, in either direction, sets `irq_raw_o` to 1 at the next rising clock edge.
- R3: A write (`clr_wr_i`=1) with `clr_wdata_i`=1 while the hidden clear bit is 0 moves that bit from 0 to 1. It clears `irq_raw_o` at the same edge, unless R6 applies.
- R4: A write of 1 while the hidden clear bit is already 1 has no effect on `irq_raw_o`.
- R5: On each cycle in which `irq_raw_o` is 0 and no write happens, the hidden clear bit returns to 0. A single write of 1 after the next set therefore clears the flag.
- R6: When a set event (R2) and a clear event (R3) fall on the same edge, the set wins and `irq_raw_o` stays 1.
- R7: After an R6 collision the hidden clear bit stays at 1. Later writes of 1 alone do not clear `irq_raw_o`.
- R8: A write with `clr_wdata_i`=0 loads 0 into the hidden clear bit. A following write of 1 then clears `irq_raw_o`.
- R9: `clr_rdata_o`, the read value of the clear control, is always 0.
- R10: `irq_o` is 1 only when `irq_raw_o` is 1 and `mask_en_i` is 1.
- R11: While `rst_ni` is low, `irq_raw_o`, `irq_o` and `cts_sync_o` are 0. After reset release, a pin that was already high raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial port clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cts_async_i | input | 1 | Raw Clear-To-Send pin level |
| clr_wr_i | input | 1 | Write strobe for the clear control |
| clr_wdata_i | input | 1 | Data bit written into the hidden clear bit |
| mask_en_i | input | 1 | Interrupt enable |
| clr_rdata_o | output | 1 | Read value of the clear control, constant 0 |
| irq_raw_o | output | 1 | Interrupt status flag |
| irq_o | output | 1 | Masked interrupt line |
| cts_sync_o | output | 1 | Synchronized pin level |

## Verification
The hidden clear bit cannot be read, so a wrong value in it shows up only at the next clear attempt. A bit stuck at 0 turns the lost-clear collision into a working clear. A bit stuck at 1 makes an ordinary single write fail to drop `irq_raw_o`. Either fault is visible one edge after that write. A faulty edge history or fill counter shows up as a spurious or missing `irq_raw_o` rise, exactly one edge after `cts_sync_o` moves, or just after reset release. The bench runs a cycle model alongside the design and compares all outputs on every cycle, so any mismatch is reported in the cycle it first appears.

// File: rtl/cts_irq_pkg.sv
package cts_irq_pkg;

  // Default depth of the synchronizer chains
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  // Register write request for the clear control
  typedef struct packed {
    logic wr;
    logic data;
  } clr_req_t;

endpackage

// File: rtl/cts_rst_sync.sv
module cts_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_comb begin
      stage_d[g] = stage_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cts_edge_det.sv
module cts_edge_det #(
  parameter int unsigned FILL = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic armed_o,
  output logic edge_o
);

  localparam int unsigned CW = $clog2(FILL + 1);

  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_d;
  logic          fill_en;
  logic          hist_q;
  logic          hist_d;
  logic          armed;

  always_comb begin
    armed   = (fill_q == CW'(FILL));
    fill_en = ~armed;
    fill_d  = fill_q + CW'(1);
    hist_d  = level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      hist_q <= 1'b0;
    end else begin
      if (fill_en) begin
        fill_q <= fill_d;
      end
      hist_q <= hist_d;
    end
  end

  // Until the sync chain and history have filled, the history only tracks the level
  assign armed_o = armed;
  assign edge_o  = armed & (level_i ^ hist_q);

endmodule

// File: rtl/cts_irq_core.sv
module cts_irq_core
  import cts_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     set_i,
  input  clr_req_t req_i,
  output logic     status_o,
  output logic     clr_bit_o
);

  logic status_q;
  logic status_d;
  logic status_en;
  logic clr_q;
  logic clr_d;
  logic clr_rise;

  always_comb begin
    clr_rise  = req_i.wr & req_i.data & ~clr_q;
    status_en = set_i | clr_rise;
    // set has priority over a simultaneous clear
    status_d  = set_i ? 1'b1 : 1'b0;
    if (req_i.wr) begin
      clr_d = req_i.data;
    end else if (!status_q) begin
      clr_d = 1'b0;
    end else begin
      clr_d = clr_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      if (status_en) begin
        status_q <= status_d;
      end
      clr_q <= clr_d;
    end
  end

  assign status_o  = status_q;
  assign clr_bit_o = clr_q;

endmodule

// File: rtl/cts_irq_latch.sv
module cts_irq_latch
  import cts_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF,
  parameter int unsigned RST_STAGES  = SYNC_DEPTH_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_async_i,
  input  logic clr_wr_i,
  input  logic clr_wdata_i,
  input  logic mask_en_i,
  output logic clr_rdata_o,
  output logic irq_raw_o,
  output logic irq_o,
  output logic cts_sync_o
);

  localparam int unsigned FILL = SYNC_STAGES + 1;

  logic     rst_int_n;
  logic     cts_lvl;
  logic     armed;
  logic     cts_edge;
  logic     status;
  logic     clr_bit;
  clr_req_t clr_req;

  assign clr_req.wr   = clr_wr_i;
  assign clr_req.data = clr_wdata_i;

  cts_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .async_i (cts_async_i),
    .sync_o  (cts_lvl)
  );

  cts_edge_det #(.FILL(FILL)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .level_i (cts_lvl),
    .armed_o (armed),
    .edge_o  (cts_edge)
  );

  cts_irq_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .set_i     (cts_edge),
    .req_i     (clr_req),
    .status_o  (status),
    .clr_bit_o (clr_bit)
  );

  assign clr_rdata_o = 1'b0;
  assign irq_raw_o   = status;
  assign irq_o       = status & mask_en_i;
  assign cts_sync_o  = cts_lvl;

endmodule

// File: rtl/cts_irq_latch_chk.sv
module cts_irq_latch_chk (
  input logic clk_i,
  input logic rst_int_n,
  input logic cts_async_i,
  input logic clr_wr_i,
  input logic clr_wdata_i,
  input logic irq_raw_o,
  input logic irq_o,
  input logic cts_sync_o,
  input logic armed,
  input logic clr_bit
);

  // R1
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    armed |-> (cts_sync_o == $past(cts_async_i, 2)));

  // R2
  edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (armed && (cts_sync_o != $past(cts_sync_o))) |=> irq_raw_o);

  // R2
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $rose(irq_raw_o) |-> ($past(armed) && ($past(cts_sync_o) != $past(cts_sync_o, 2))));

  // R3
  clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $fell(irq_raw_o) |-> $past(clr_wr_i && clr_wdata_i && !clr_bit));

  // R4
  stuck_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (clr_wr_i && clr_wdata_i && clr_bit && irq_raw_o) |=> irq_raw_o);

  // R5
  hw_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (!irq_raw_o && !clr_wr_i) |=> !clr_bit);

  // R10
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    irq_o |-> irq_raw_o);

endmodule

bind cts_irq_latch cts_irq_latch_chk u_chk (
  .clk_i       (clk_i),
  .rst_int_n   (rst_int_n),
  .cts_async_i (cts_async_i),
  .clr_wr_i    (clr_wr_i),
  .clr_wdata_i (clr_wdata_i),
  .irq_raw_o   (irq_raw_o),
  .irq_o       (irq_o),
  .cts_sync_o  (cts_sync_o),
  .armed       (armed),
  .clr_bit     (clr_bit)
);

// File: tb/sim_cts_irq_latch.sv
`timescale 1ns/1ps
module sim_cts_irq_latch;

  logic clk = 1'b0;
  logic rst_n;
  logic pin;
  logic wr;
  logic wd;
  logic mask;
  logic rd_o, raw_o, irq_ln, sync_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cts_irq_latch u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cts_async_i (pin),
    .clr_wr_i    (wr),
    .clr_wdata_i (wd),
    .mask_en_i   (mask),
    .clr_rdata_o (rd_o),
    .irq_raw_o   (raw_o),
    .irq_o       (irq_ln),
    .cts_sync_o  (sync_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle model built from the requirements
  logic [1:0] m_rs;
  logic m_s1, m_s2, m_hist, m_stat, m_clr;
  int   m_fill;

  function automatic logic exp_set(input int fill, input logic lvl, input logic hist);
    return (fill == 3) && (lvl != hist);
  endfunction

  function automatic logic exp_clear(input logic w, input logic d, input logic bitv);
    return w && d && !bitv;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 2'b00; m_s1 = 0; m_s2 = 0; m_hist = 0; m_stat = 0; m_clr = 0; m_fill = 0;
    end else if (!m_rs[1]) begin
      m_rs = {m_rs[0], 1'b1};
    end else begin
      logic st, cv, nstat, nclr;
      st = exp_set(m_fill, m_s2, m_hist);
      cv = exp_clear(wr, wd, m_clr);
      nstat = st ? 1'b1 : (cv ? 1'b0 : m_stat);
      nclr  = wr ? wd : (m_stat ? m_clr : 1'b0);
      m_hist = m_s2;
      m_s2 = m_s1;
      m_s1 = pin;
      if (m_fill < 3) m_fill++;
      m_stat = nstat;
      m_clr  = nclr;
    end
  end

  always @(negedge clk) begin
    #1;
    if (model_on) begin
      check("R1 model sync", sync_o, m_s2);
      check("R2/R3/R6 model status", raw_o, m_stat);
      check("R10 model irq", irq_ln, m_stat & mask);
      check("R9 read value", rd_o, 1'b0);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr1(input logic d);
    wr = 1'b1; wd = d;
    step(1);
    wr = 1'b0; wd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pin = 1'b1; wr = 1'b0; wd = 1'b0; mask = 1'b1;
    step(3);
    #1;
    // R11 reset state
    check("R11 raw in reset", raw_o, 1'b0);
    check("R11 irq in reset", irq_ln, 1'b0);
    check("R11 sync in reset", sync_o, 1'b0);
    check("R9 read in reset", rd_o, 1'b0);
    rst_n = 1'b1;
    model_on = 1'b1;
    step(8);
    // R11: pin high at release raises nothing
    check("R11 no irq after release", raw_o, 1'b0);
    check("R1 sync level after release", sync_o, 1'b1);

    // R1 latency and R2 falling edge
    pin = 1'b0;
    step(1);
    check("R1 sync after one edge", sync_o, 1'b1);
    step(1);
    check("R1 sync after two edges", sync_o, 1'b0);
    check("R2 not yet set", raw_o, 1'b0);
    step(1);
    check("R2 set on falling", raw_o, 1'b1);

    // R10 mask
    mask = 1'b0; #1;
    check("R10 masked", irq_ln, 1'b0);
    mask = 1'b1; #1;
    check("R10 unmasked", irq_ln, 1'b1);

    // R3 ordinary clear
    wr1(1'b1);
    check("R3 clear on rising bit", raw_o, 1'b0);
    step(2);

    // R2 rising edge, R5 rearmed bit allows single clear
    pin = 1'b1;
    step(3);
    check("R2 set on rising", raw_o, 1'b1);
    wr1(1'b1);
    check("R5 rearmed clear works", raw_o, 1'b0);
    step(2);

    // R6 collision: status set, then clear on same edge as new set
    pin = 1'b0;
    step(3);
    check("R2 set before collision", raw_o, 1'b1);
    pin = 1'b1;
    step(2);
    wr1(1'b1);
    check("R6 set wins collision", raw_o, 1'b1);
    step(3);
    wr1(1'b1);
    step(1);
    check("R7 lost clear stays set", raw_o, 1'b1);
    wr1(1'b1);
    check("R4 repeated write of one", raw_o, 1'b1);
    wr1(1'b0);
    check("R8 write zero keeps status", raw_o, 1'b1);
    wr1(1'b1);
    check("R8 clear after write zero", raw_o, 1'b0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 8) == 0) pin = ~pin;
      if (($urandom % 5) == 0) begin
        wr = 1'b1; wd = (($urandom % 4) != 0);
      end else begin
        wr = 1'b0; wd = $urandom % 2;
      end
      if (($urandom % 16) == 0) mask = $urandom % 2;
      step(1);
    end
    wr = 1'b0;
    step(2);
    finish_run();
  end

endmodule